// File: doc/BRIEF.md
# Snooping Coherence-State Controller with Atomic Line Hold

This block keeps the four-state coherence status (Modified, Exclusive, Shared, Invalid) for a small, direct-indexed set of lines in one private cache. A core issues read, write, lock and unlock requests. Missing ownership is obtained over a broadcast bus: a shared read fills a line, and a read-for-ownership invalidates every peer copy. Snoops from peers come back in on a separate port. Each snoop that is taken gets a registered response carrying a hit flag and a dirty flag. The dirty flag tells the system that a writeback is due.

A lock marks a line as held for a read-modify-write. While the lock is held, any peer snoop to that line is stalled through a stall output, and the peer keeps its snoop valid. Only the local core can then touch the line. The snoop is taken in the cycle after the core unlocks, so the atomic sequence cannot be split. Data storage, replacement and memory timing sit outside the block. The line size is a parameter, 64 bytes by default, and the address width must equal the offset bits plus the index bits.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid and unlocked. The outputs req_done, bus_req_valid, snp_stall and snp_resp_valid are low.
- R2: A read (req_op 0) to a valid line completes with no bus request. A read miss raises bus_req_valid with bus_req_rdx=0 and the line-aligned address, and holds it until bus_grant. The line fills as Shared if bus_shared_in is high at the grant and as Exclusive otherwise.
- R3: A write (req_op 1) to an Exclusive or Modified line completes with no bus request and leaves the line Modified. A write to a Shared or Invalid line first issues bus_req_rdx=1 and leaves the line Modified.
- R4: A lock (req_op 2) on an Exclusive or Modified line is granted with no bus request. On any other line it issues bus_req_rdx=1 and is granted only once the line is Exclusive.
- R5: While a line is locked, read snoops (snp_wr=0) and write snoops (snp_wr=1) to it keep snp_stall high and produce no response. The line state stays unchanged. An unlock (req_op 3) releases the line, and the held snoop is then taken.
- R6: A write snoop to an unlocked line leaves it Invalid. The response has its dirty flag set exactly when the line was Modified, which signals a writeback.
- R7: A read snoop to an unlocked Modified or Exclusive line leaves it Shared, with the dirty flag set only if it was Modified. A Shared line stays Shared.
- R8: A snoop that is taken gets snp_resp_valid in the next cycle. snp_resp_hit reports that the line was not Invalid, and snp_resp_dirty reports that it was Modified. Any byte offset within a line addresses the same state.
- R9: A lock on one line does not stall snoops to other lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid, held until req_done |
| req_op | input | 2 | 0 read, 1 write, 2 lock, 3 unlock |
| req_addr | input | ADDR_W | Core byte address |
| req_done | output | 1 | One-cycle completion pulse |
| bus_req_valid | output | 1 | Bus request, held until grant |
| bus_req_rdx | output | 1 | 1 = read-for-ownership (invalidate), 0 = shared read |
| bus_req_addr | output | ADDR_W | Line-aligned bus address |
| bus_grant | input | 1 | Bus transaction completes this cycle |
| bus_shared_in | input | 1 | A peer holds the line (sampled at grant) |
| snp_valid | input | 1 | Peer snoop valid, held while stalled |
| snp_wr | input | 1 | 1 = write snoop, 0 = read snoop |
| snp_addr | input | ADDR_W | Snoop byte address |
| snp_stall | output | 1 | Snoop held back (locked line or fill in flight) |
| snp_resp_valid | output | 1 | Snoop response valid |
| snp_resp_hit | output | 1 | Line was present |
| snp_resp_dirty | output | 1 | Line was Modified (writeback due) |

## Verification
The bench goes after the atomic window. A read snoop and a write snoop each arrive while a line is locked. A local write then lands during the stall. A design that leaked the snoop would answer too early, or would report the line as clean and drop the writeback. It also checks that Shared and Exclusive fills differ by whether a later write needs a read-for-ownership. A design that ignored the shared response would silently skip the invalidate. It checks byte offsets inside one line and snoops to a neighbour of a locked line; a wrong index split or an over-broad stall shows up there as the wrong response or a hang.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
   typedef enum logic [1:0] {
      ST_I = 2'b00,
      ST_S = 2'b01,
      ST_E = 2'b10,
      ST_M = 2'b11
   } mesi_t;

   typedef enum logic [1:0] {
      OP_READ   = 2'd0,
      OP_WRITE  = 2'd1,
      OP_LOCK   = 2'd2,
      OP_UNLOCK = 2'd3
   } core_op_t;

   typedef enum logic [1:0] {
      FSM_IDLE = 2'd0,
      FSM_BUS  = 2'd1,
      FSM_RESP = 2'd2
   } fsm_t;
endpackage

// File: rtl/mesi_line.sv
module mesi_line
   import mesi_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  fill_en,
   input  mesi_t fill_st,
   input  logic  store_en,
   input  logic  lock_set,
   input  logic  lock_clr,
   input  logic  snp_en,
   input  logic  snp_wr,
   output mesi_t state,
   output logic  locked
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_I;
         locked <= 1'b0;
      end else begin
         if (snp_en)
            state <= snp_wr ? ST_I : ((state == ST_I) ? ST_I : ST_S);
         else if (fill_en)
            state <= fill_st;
         else if (store_en)
            state <= ST_M;
         if (lock_set)
            locked <= 1'b1;
         else if (lock_clr)
            locked <= 1'b0;
      end
   end

   assert_store_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      store_en |-> (state == ST_E || state == ST_M));
   assert_lock_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (state == ST_E || state == ST_M));
   assert_locked_no_snoop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> !snp_en);
   assert_wr_snoop_inval_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_en && snp_wr) |=> state == ST_I);
   assert_rd_snoop_share_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_en && !snp_wr && state != ST_I) |=> state == ST_S);
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
   import mesi_pkg::*;
#(
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_op,
   input  logic [IDX_W-1:0] req_idx,
   input  mesi_t            req_st,
   input  logic             snp_block,
   input  logic             bus_grant,
   input  logic             bus_shared_in,
   output logic             req_done,
   output logic             bus_req_valid,
   output logic             bus_req_rdx,
   output logic [IDX_W-1:0] act_idx,
   output logic             fill_en,
   output mesi_t            fill_st,
   output logic             store_en,
   output logic             lock_set,
   output logic             lock_clr
);
   fsm_t             fsm_q, fsm_d;
   core_op_t         op_q;
   logic [IDX_W-1:0] idx_q;
   logic             owned, accept;

   assign owned   = (req_st == ST_E) || (req_st == ST_M);
   assign accept  = (fsm_q == FSM_IDLE) && req_valid && !snp_block;
   assign act_idx = (fsm_q == FSM_IDLE) ? req_idx : idx_q;

   always_comb begin
      fsm_d       = fsm_q;
      fill_en     = 1'b0;
      fill_st     = ST_I;
      store_en    = 1'b0;
      lock_set    = 1'b0;
      lock_clr    = 1'b0;
      bus_req_rdx = (op_q != OP_READ);
      case (fsm_q)
         FSM_IDLE: if (accept) begin
            case (core_op_t'(req_op))
               OP_READ:   fsm_d = (req_st != ST_I) ? FSM_RESP : FSM_BUS;
               OP_WRITE:  begin store_en = owned; fsm_d = owned ? FSM_RESP : FSM_BUS; end
               OP_LOCK:   begin lock_set = owned; fsm_d = owned ? FSM_RESP : FSM_BUS; end
               default:   begin lock_clr = 1'b1;  fsm_d = FSM_RESP; end
            endcase
         end
         FSM_BUS: if (bus_grant) begin
            fill_en  = 1'b1;
            lock_set = (op_q == OP_LOCK);
            case (op_q)
               OP_WRITE: fill_st = ST_M;
               OP_LOCK:  fill_st = ST_E;
               default:  fill_st = bus_shared_in ? ST_S : ST_E;
            endcase
            fsm_d = FSM_RESP;
         end
         default: fsm_d = FSM_IDLE;
      endcase
   end

   assign bus_req_valid = (fsm_q == FSM_BUS);
   assign req_done      = (fsm_q == FSM_RESP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsm_q <= FSM_IDLE;
         op_q  <= OP_READ;
         idx_q <= '0;
      end else begin
         fsm_q <= fsm_d;
         if (accept) begin
            op_q  <= core_op_t'(req_op);
            idx_q <= req_idx;
         end
      end
   end

   assert_bus_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && !bus_grant) |=> (bus_req_valid && $stable(bus_req_rdx) && $stable(act_idx)));
   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> !req_done);
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
   import mesi_pkg::*;
#(
   parameter int NUM_LINES  = 4,
   parameter int LINE_BYTES = 64,
   parameter int ADDR_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_done,
   output logic              bus_req_valid,
   output logic              bus_req_rdx,
   output logic [ADDR_W-1:0] bus_req_addr,
   input  logic              bus_grant,
   input  logic              bus_shared_in,
   input  logic              snp_valid,
   input  logic              snp_wr,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_stall,
   output logic              snp_resp_valid,
   output logic              snp_resp_hit,
   output logic              snp_resp_dirty
);
   localparam int OFS_W = $clog2(LINE_BYTES);
   localparam int SEL_W = $clog2(NUM_LINES);
   localparam int IDX_W = (SEL_W == 0) ? 1 : SEL_W;

   if (LINE_BYTES < 4 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 4");
   end
   if (NUM_LINES < 1) begin : g_bad_lines
      $error("NUM_LINES must be at least 1");
   end
   if (ADDR_W != OFS_W + SEL_W) begin : g_bad_addr
      $error("ADDR_W must equal offset bits plus index bits");
   end

   logic [IDX_W-1:0]     req_idx, snp_idx, act_idx;
   mesi_t                line_st [NUM_LINES];
   logic [NUM_LINES-1:0] line_lk;
   logic                 fill_en, store_en, lock_set, lock_clr;
   mesi_t                fill_st;
   logic                 snp_take, snp_block, fill_busy;

   if (SEL_W > 0) begin : g_multi
      assign req_idx      = req_addr[OFS_W +: SEL_W];
      assign snp_idx      = snp_addr[OFS_W +: SEL_W];
      assign bus_req_addr = {act_idx, {OFS_W{1'b0}}};
   end else begin : g_single
      assign req_idx      = 1'b0;
      assign snp_idx      = 1'b0;
      assign bus_req_addr = '0;
   end

   assign fill_busy = fill_en && (act_idx == snp_idx);
   assign snp_stall = snp_valid && (line_lk[snp_idx] || fill_busy);
   assign snp_take  = snp_valid && !snp_stall;
   assign snp_block = snp_valid && (snp_idx == req_idx) && !line_lk[snp_idx];

   mesi_req_fsm #(.IDX_W(IDX_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx),
      .req_st(line_st[req_idx]), .snp_block(snp_block),
      .bus_grant(bus_grant), .bus_shared_in(bus_shared_in),
      .req_done(req_done), .bus_req_valid(bus_req_valid), .bus_req_rdx(bus_req_rdx),
      .act_idx(act_idx), .fill_en(fill_en), .fill_st(fill_st),
      .store_en(store_en), .lock_set(lock_set), .lock_clr(lock_clr)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic sel_loc, sel_snp;
      assign sel_loc = (act_idx == IDX_W'(i));
      assign sel_snp = (snp_idx == IDX_W'(i));
      mesi_line u_line (
         .clk(clk), .rst_n(rst_n),
         .fill_en(fill_en && sel_loc), .fill_st(fill_st),
         .store_en(store_en && sel_loc),
         .lock_set(lock_set && sel_loc), .lock_clr(lock_clr && sel_loc),
         .snp_en(snp_take && sel_snp), .snp_wr(snp_wr),
         .state(line_st[i]), .locked(line_lk[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snp_resp_valid <= 1'b0;
         snp_resp_hit   <= 1'b0;
         snp_resp_dirty <= 1'b0;
      end else begin
         snp_resp_valid <= snp_take;
         snp_resp_hit   <= snp_take && (line_st[snp_idx] != ST_I);
         snp_resp_dirty <= snp_take && (line_st[snp_idx] == ST_M);
      end
   end

   assert_dirty_is_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      snp_resp_dirty |-> snp_resp_hit);
   assert_stall_no_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      snp_stall |=> !snp_resp_valid);
   assert_take_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && !snp_stall) |=> snp_resp_valid);
endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic          req_done, bus_req_valid, bus_req_rdx;
   logic [AW-1:0] bus_req_addr;
   logic          bus_grant = 1'b0, bus_shared_in = 1'b0;
   logic          snp_valid = 1'b0, snp_wr = 1'b0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_stall, snp_resp_valid, snp_resp_hit, snp_resp_dirty;

   int checks = 0, fails = 0, cycles = 0;
   logic next_shared = 1'b0;
   logic [AW:0] exp_bus [$];
   logic [1:0]  exp_snp [$];
   string       bus_tag [$];
   string       snp_tag [$];

   always #10 clk = ~clk;

   mesi_snoop_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_done(req_done), .bus_req_valid(bus_req_valid),
      .bus_req_rdx(bus_req_rdx), .bus_req_addr(bus_req_addr), .bus_grant(bus_grant),
      .bus_shared_in(bus_shared_in), .snp_valid(snp_valid), .snp_wr(snp_wr),
      .snp_addr(snp_addr), .snp_stall(snp_stall), .snp_resp_valid(snp_resp_valid),
      .snp_resp_hit(snp_resp_hit), .snp_resp_dirty(snp_resp_dirty)
   );

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // monitor and always-ready memory responder
   always @(negedge clk) begin
      if (rst_n && bus_req_valid && !bus_grant) begin
         if (exp_bus.size() == 0)
            check(1'b0, "R2 unexpected bus request", {bus_req_rdx, bus_req_addr}, 0);
         else begin
            logic [AW:0] e;
            string t;
            e = exp_bus.pop_front();
            t = bus_tag.pop_front();
            check({bus_req_rdx, bus_req_addr} == e, t, {bus_req_rdx, bus_req_addr}, e);
         end
         bus_grant     = 1'b1;
         bus_shared_in = next_shared;
      end else begin
         bus_grant     = 1'b0;
         bus_shared_in = 1'b0;
      end
      if (rst_n && snp_resp_valid) begin
         if (exp_snp.size() == 0)
            check(1'b0, "R8 unexpected snoop response", {snp_resp_hit, snp_resp_dirty}, 0);
         else begin
            logic [1:0] e;
            string t;
            e = exp_snp.pop_front();
            t = snp_tag.pop_front();
            check({snp_resp_hit, snp_resp_dirty} == e, t, {snp_resp_hit, snp_resp_dirty}, e);
         end
      end
   end

   task automatic do_req(input logic [1:0] op, input logic [AW-1:0] a, input logic sh,
                         input bit want_bus, input logic rdx, input string tag);
      if (want_bus) begin
         exp_bus.push_back({rdx, a & 8'hC0});
         bus_tag.push_back(tag);
      end
      @(negedge clk);
      next_shared = sh;
      req_op = op; req_addr = a; req_valid = 1'b1;
      do @(negedge clk); while (!req_done);
      req_valid = 1'b0;
      check(exp_bus.size() == 0, {tag, " bus request count"}, exp_bus.size(), 0);
      while (exp_bus.size() != 0) begin
         void'(exp_bus.pop_front());
         void'(bus_tag.pop_front());
      end
   endtask

   task automatic snoop_begin(input logic wr, input logic [AW-1:0] a, input logic hit,
                              input logic dirty, input string tag);
      exp_snp.push_back({hit, dirty});
      snp_tag.push_back(tag);
      @(negedge clk);
      snp_wr = wr; snp_addr = a; snp_valid = 1'b1;
   endtask

   task automatic snoop_finish();
      do @(negedge clk); while (!snp_resp_valid);
      snp_valid = 1'b0;
   endtask

   task automatic snoop(input logic wr, input logic [AW-1:0] a, input logic hit,
                        input logic dirty, input string tag);
      snoop_begin(wr, a, hit, dirty, tag);
      snoop_finish();
   endtask

   task automatic expect_stalled(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(snp_stall && !snp_resp_valid, tag, {snp_stall, snp_resp_valid}, 2);
      end
   endtask

   initial begin : watchdog
      while (cycles < 100000) begin
         @(posedge clk);
         cycles++;
      end
      check(1'b0, "watchdog expired", cycles, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs after reset
      check({req_done, bus_req_valid, snp_stall, snp_resp_valid} == 4'b0, "R1 reset outputs",
            {req_done, bus_req_valid, snp_stall, snp_resp_valid}, 0);
      snoop(1'b0, 8'h00, 1'b0, 1'b0, "R1 line0 invalid after reset");

      // R2 miss fills Exclusive; R3/R8 write at another offset completes without bus
      do_req(2'd0, 8'h00, 1'b0, 1'b1, 1'b0, "R2 read miss shared-read");
      do_req(2'd1, 8'h05, 1'b0, 1'b0, 1'b0, "R3 write to Exclusive no bus");
      snoop(1'b0, 8'h3F, 1'b1, 1'b1, "R7 read snoop on Modified");
      snoop(1'b0, 8'h00, 1'b1, 1'b0, "R7 read snoop on Shared stays clean");
      do_req(2'd1, 8'h00, 1'b0, 1'b1, 1'b1, "R3 write to Shared issues rdx");
      snoop(1'b1, 8'h10, 1'b1, 1'b1, "R6 write snoop on Modified writeback");
      snoop(1'b0, 8'h00, 1'b0, 1'b0, "R6 line invalid after write snoop");

      // R2 shared fill
      do_req(2'd0, 8'h47, 1'b1, 1'b1, 1'b0, "R2 read miss with shared response");
      snoop(1'b0, 8'h40, 1'b1, 1'b0, "R2 shared fill clean");
      do_req(2'd1, 8'h40, 1'b0, 1'b1, 1'b1, "R2 Shared fill forces rdx on write");
      snoop(1'b0, 8'h40, 1'b1, 1'b1, "R3 line Modified after upgrade");

      // R4/R5 lock on invalid line, read snoop deferred across a local write
      do_req(2'd2, 8'h80, 1'b0, 1'b1, 1'b1, "R4 lock on Invalid issues rdx");
      snoop_begin(1'b0, 8'h80, 1'b1, 1'b1, "R5 deferred read snoop sees local write");
      expect_stalled(3, "R5 read snoop stalled while locked");
      do_req(2'd1, 8'h88, 1'b0, 1'b0, 1'b0, "R5 write during lock no bus");
      expect_stalled(2, "R5 still stalled after local write");
      do_req(2'd3, 8'h80, 1'b0, 1'b0, 1'b0, "R5 unlock");
      snoop_finish();

      // R4 lock on Shared, R9 neighbour snoop, R5 write snoop deferred
      do_req(2'd2, 8'h80, 1'b0, 1'b1, 1'b1, "R4 lock on Shared issues rdx");
      snoop(1'b1, 8'hC0, 1'b0, 1'b0, "R9 neighbour snoop not stalled");
      snoop_begin(1'b1, 8'h80, 1'b1, 1'b0, "R5 deferred write snoop clean Exclusive");
      expect_stalled(3, "R5 write snoop stalled while locked");
      do_req(2'd3, 8'h80, 1'b0, 1'b0, 1'b0, "R5 unlock second");
      snoop_finish();
      snoop(1'b0, 8'h80, 1'b0, 1'b0, "R6 line invalid after deferred write snoop");

      // R4 lock on Exclusive without bus; R2 read hit
      do_req(2'd0, 8'hC0, 1'b0, 1'b1, 1'b0, "R2 read miss line3");
      do_req(2'd2, 8'hC4, 1'b0, 1'b0, 1'b0, "R4 lock on Exclusive no bus");
      do_req(2'd3, 8'hC0, 1'b0, 1'b0, 1'b0, "R5 unlock line3");
      do_req(2'd0, 8'hC0, 1'b0, 1'b0, 1'b0, "R2 read hit no bus");
      do_req(2'd1, 8'hC0, 1'b0, 1'b0, 1'b0, "R3 line3 still Exclusive");
      snoop(1'b0, 8'hC0, 1'b1, 1'b1, "R8 response flags Modified");

      repeat (2) @(negedge clk);
      check(exp_snp.size() == 0, "R8 missing snoop responses", exp_snp.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule